// File: doc/BRIEF.md
# SPI Receive Slave with Low-Power Wake-up

This block is the receive side of a serial peripheral port in a small controller. Acting as a slave, it collects bytes shifted in on a serial clock and data line while a select line is active. Software sees two byte-wide locations. One holds the last received byte. The other is a control/status word. That word carries an end-of-transfer flag, an overrun flag and a mode-fault flag, next to the control bits. These bits are enable, interrupt enable, master, software-select mode and the software select level. All three events drive one shared interrupt line.

The block follows the controller's power states. In wait it keeps working, and any enabled event asks for wake-up. In halt the register interface is frozen. Reception goes on only if the slave was selected at the moment halt began. A byte completed in that state produces the wake-up request, and it is the only event that can do so. After the controller leaves halt, the first transfer completed in slave mode only brings the port back to normal operation and is dropped. Leaving slave mode clears that recovery state at once.

Top module: `spi_slave_lp`

## Requirements
- R1: While selected in slave mode (enable=1, master=0), bits are taken MSB first on rising SCK edges. The 8th bit stores the byte in the data location (address 1) and sets end-of-transfer (status bit 7), provided the flag was clear.
- R2: With software-select mode (control bit 3) at 0, select is the external pin ss_ni, active low. With it at 1, select is control bit 4, also active low, and the pin is ignored. Deselection discards a partial byte.
- R3: A byte completed while end-of-transfer is still set sets overrun (status bit 6). The data location keeps the earlier byte.
- R4: A read of address 0 immediately followed by a read of address 1 clears all three flags. A data read without the preceding status read clears nothing.
- R5: irq_o is high exactly when interrupt enable (control bit 1) is set, irq_mask_i is low and at least one flag is set.
- R6: While wait_i is high and halt_i is low, wake_o is high when interrupt enable is set and any flag is set, whatever irq_mask_i is.
- R7: Reception continues during halt only if the block was a selected slave in the cycle halt_i rose. Otherwise SCK edges in halt are not counted and no byte is stored.
- R8: During halt, register writes are ignored and no mode fault is raised.
- R9: During halt, wake_o is high only when end-of-transfer is set and interrupt enable is set.
- R10: If halt is entered in slave mode, the first byte completed after halt_i falls is dropped (no flag, no data). Leaving slave mode cancels this.
- R11: Select going active while enable and master (control bit 2) are set raises mode fault (status bit 5), clears master, and drops outs_en_o.
- R12: After reset, the control word and flags are 0, and irq_o, wake_o and outs_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| ss_ni | input | 1 | External slave select, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | 0 = control/status, 1 = data |
| reg_wdata_i | input | 8 | Write data (bits 4:0 to control) |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_mask_i | input | 1 | Global interrupt mask |
| wait_i | input | 1 | Wait power mode |
| halt_i | input | 1 | Halt power mode |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wake-up request |
| outs_en_o | output | 1 | Port output drivers enabled (master) |

## Verification
A wrong bit count or shift order shows as a wrong byte at the data location, read a few cycles after the eighth edge. A stuck or early flag shows on irq_o within one cycle. A lost arming decision at halt entry shows as a missing wake_o once the in-halt byte completes. A recovery state that is not set or not cleared shows on the very next transfer after halt, which is either wrongly stored or wrongly dropped. Frozen-register faults show when the control word is read back after halt.

// File: rtl/spi_lp_pkg.sv
package spi_lp_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned CTRL_W = 5;

  typedef struct packed {
    logic ssi;     // software select level, active low
    logic ssm;     // 1: select from ssi
    logic master;
    logic ie;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic eot;
    logic ovr;
    logic modf;
  } flags_t;

  typedef enum logic {
    ADDR_CSR  = 1'b0,
    ADDR_DATA = 1'b1
  } addr_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RESET_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
        else         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              sel_i,
  input  logic              hold_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q;
  logic              rise;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] nxt;
  logic              done_q;
  logic [DATA_W-1:0] byte_q;

  assign rise = sck_i & ~sck_q;
  assign nxt  = {sh_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      byte_q <= '0;
    end else begin
      sck_q  <= sck_i;
      done_q <= 1'b0;
      if (!sel_i) begin
        cnt_q <= '0;
      end else if (!hold_i && rise) begin
        sh_q <= nxt;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          byte_q <= nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/spi_lp_ctrl.sv
module spi_lp_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic slave_i,
  input  logic sel_i,
  input  logic done_i,
  output logic hold_o,
  output logic accept_o
);
  logic halt_q;
  logic armed_q;
  logic recover_q;
  logic entry;
  logic arm_now;

  assign entry   = halt_i & ~halt_q;
  assign arm_now = entry & sel_i & slave_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q    <= 1'b0;
      armed_q   <= 1'b0;
      recover_q <= 1'b0;
    end else begin
      halt_q <= halt_i;
      if (!halt_i)    armed_q <= 1'b0;
      else if (entry) armed_q <= arm_now;
      if (!slave_i)                    recover_q <= 1'b0;
      else if (entry)                  recover_q <= 1'b1;
      else if (!halt_i && done_i)      recover_q <= 1'b0;
    end
  end

  // in halt only an armed slave keeps counting
  assign hold_o   = halt_i & ~(armed_q | arm_now);
  // first byte after halt exit only restores normal state
  assign accept_o = done_i & ~(recover_q & ~halt_i);
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_lp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              wait_i,
  input  logic              irq_mask_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              sel_i,
  output ctrl_t             ctrl_o,
  output flags_t            flags_o,
  output logic [DATA_W-1:0] data_o,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  ctrl_t             ctrl_q;
  flags_t            flags_q;
  logic [DATA_W-1:0] data_q;
  logic              rd_seq_q;
  logic              bus_ok;
  logic              is_csr;
  logic              clr;
  logic              fault;
  logic              eot_eff;

  assign bus_ok  = ~halt_i;
  assign is_csr  = (addr_e'(reg_addr_i) == ADDR_CSR);
  assign clr     = bus_ok & reg_rd_i & ~is_csr & rd_seq_q;
  assign fault   = ~halt_i & ctrl_q.en & ctrl_q.master & sel_i;
  assign eot_eff = flags_q.eot & ~clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      flags_q  <= '0;
      data_q   <= '0;
      rd_seq_q <= 1'b0;
    end else begin
      if (bus_ok) begin
        if (reg_wr_i && is_csr) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
        if (reg_wr_i || reg_rd_i) rd_seq_q <= reg_rd_i & is_csr;
      end
      if (clr) flags_q <= '0;
      if (fault) begin
        flags_q.modf  <= 1'b1;
        ctrl_q.master <= 1'b0;
      end
      if (accept_i) begin
        if (eot_eff) begin
          flags_q.ovr <= 1'b1;
        end else begin
          data_q      <= byte_i;
          flags_q.eot <= 1'b1;
        end
      end
    end
  end

  assign ctrl_o      = ctrl_q;
  assign flags_o     = flags_q;
  assign data_o      = data_q;
  assign reg_rdata_o = is_csr ? {flags_q, ctrl_q} : REG_W'(data_q);
  assign irq_o       = ctrl_q.ie & ~irq_mask_i & (|flags_q);
  assign wake_o      = ctrl_q.ie & (halt_i ? flags_q.eot : (wait_i & (|flags_q)));
endmodule

// File: rtl/spi_slave_lp.sv
module spi_slave_lp
  import spi_lp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             ss_ni,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             irq_mask_i,
  input  logic             wait_i,
  input  logic             halt_i,
  output logic             irq_o,
  output logic             wake_o,
  output logic             outs_en_o
);
  logic              sck_s;
  logic              mosi_s;
  logic              ss_n_s;
  ctrl_t             ctrl;
  flags_t            flags;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] rx_data;
  logic              done;
  logic              accept;
  logic              hold;
  logic              sel;
  logic              slave;

  spi_sync #(
    .WIDTH     (3),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b100)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, mosi_i, sck_i}),
    .q_o    ({ss_n_s, mosi_s, sck_s})
  );

  assign sel   = ~(ctrl.ssm ? ctrl.ssi : ss_n_s);
  assign slave = ctrl.en & ~ctrl.master;

  spi_rx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_s),
    .mosi_i (mosi_s),
    .sel_i  (sel & slave),
    .hold_i (hold),
    .done_o (done),
    .byte_o (rx_byte)
  );

  spi_lp_ctrl i_lp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .halt_i   (halt_i),
    .slave_i  (slave),
    .sel_i    (sel),
    .done_i   (done),
    .hold_o   (hold),
    .accept_o (accept)
  );

  spi_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (halt_i),
    .wait_i      (wait_i),
    .irq_mask_i  (irq_mask_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .accept_i    (accept),
    .byte_i      (rx_byte),
    .sel_i       (sel),
    .ctrl_o      (ctrl),
    .flags_o     (flags),
    .data_o      (rx_data),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
  );

  assign outs_en_o = ctrl.en & ctrl.master;
endmodule

// File: rtl/spi_slave_lp_chk.sv
module spi_slave_lp_chk
  import spi_lp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic              irq_mask_i,
  input logic              irq_o,
  input logic              wake_o,
  input logic              outs_en_o,
  input ctrl_t             ctrl_i,
  input flags_t            flags_i,
  input logic [DATA_W-1:0] data_i
);
  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!irq_mask_i && ctrl_i.ie));

  assert_wake_needs_ie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ctrl_i.ie);

  assert_halt_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (!halt_i || $stable(ctrl_i)));

  assert_halt_wake_eot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && wake_o) |-> flags_i.eot);

  assert_ovr_keeps_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i.ovr) |-> ($stable(data_i) && flags_i.eot));

  assert_modf_drops_master_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i.modf) |-> (!ctrl_i.master && !outs_en_o));
endmodule

bind spi_slave_lp spi_slave_lp_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_i     (halt_i),
  .irq_mask_i (irq_mask_i),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .outs_en_o  (outs_en_o),
  .ctrl_i     (ctrl),
  .flags_i    (flags),
  .data_i     (rx_data)
);

// File: tb/test_spi_slave_lp.sv
`timescale 1ns/1ps
module test_spi_slave_lp;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       mask = 1'b0, wt = 1'b0, halt = 1'b0;
  logic       irq, wake, outs_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] obs;
  event       got_ev;

  always #2.5 clk = ~clk;

  spi_slave_lp i_spi_slave_lp (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_mask_i(mask), .wait_i(wt), .halt_i(halt),
    .irq_o(irq), .wake_o(wake), .outs_en_o(outs_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk); wr = 1'b1; addr = 1'b0; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] v);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi = b[i];
      idle(HALF); sck = 1'b1;
      idle(HALF); sck = 1'b0;
    end
    idle(8);
  endtask

  // driver: pushes expected byte when it should land in the data location
  task automatic send_byte(input logic [7:0] b, input bit expect_store);
    if (expect_store) exp_q.push_back(b);
    send_bits(b, 8);
  endtask

  task automatic drain();
    logic [7:0] s, d;
    read_reg(1'b0, s);
    check("R1 eot before drain", {31'd0, s[7]}, 1);
    read_reg(1'b1, d);
    obs = d;
    -> got_ev;
    idle(1);
  endtask

  // monitor / scoreboard
  always @(got_ev) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R1 scoreboard: actual %0h expected none", obs);
    end else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      if (obs !== e) begin
        errors++;
        $display("FAIL R1 scoreboard: actual %0h expected %0h", obs, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    idle(4);
    check("R12 irq", {31'd0, irq}, 0);
    check("R12 wake", {31'd0, wake}, 0);
    check("R12 outs_en", {31'd0, outs_en}, 0);
    rst_n = 1'b1;
    read_reg(1'b0, s);
    check("R12 status", {24'd0, s}, 0);

    // basic receive
    write_ctrl(8'h03);
    ss_n = 1'b0; idle(4);
    send_byte(8'hA5, 1);
    check("R5 irq on eot", {31'd0, irq}, 1);
    read_reg(1'b0, s);
    check("R1 status eot", {24'd0, s}, 32'h83);
    drain();
    check("R4 irq cleared", {31'd0, irq}, 0);

    // overrun
    send_byte(8'h3C, 1);
    send_byte(8'h99, 0);
    read_reg(1'b0, s);
    check("R3 ovr set", {24'd0, s}, 32'hC3);
    drain();
    read_reg(1'b0, s);
    check("R4 flags cleared", {24'd0, s}, 32'h03);

    // data read alone does not clear
    send_byte(8'h5A, 1);
    write_ctrl(8'h03);
    read_reg(1'b1, d);
    check("R4 raw data", {24'd0, d}, 32'h5A);
    read_reg(1'b0, s);
    check("R4 no clear without status", {24'd0, s}, 32'h83);
    drain();

    // mask and enable
    send_byte(8'h11, 1);
    mask = 1'b1; idle(1);
    check("R5 masked", {31'd0, irq}, 0);
    mask = 1'b0; idle(1);
    check("R5 unmasked", {31'd0, irq}, 1);
    write_ctrl(8'h01);
    check("R5 ie off", {31'd0, irq}, 0);
    write_ctrl(8'h03);
    drain();

    // wait mode
    wt = 1'b1; idle(1);
    check("R6 no event", {31'd0, wake}, 0);
    send_byte(8'h22, 1);
    check("R6 wake on eot", {31'd0, wake}, 1);
    mask = 1'b1; idle(1);
    check("R6 wake ignores mask", {31'd0, wake}, 1);
    mask = 1'b0;
    drain();
    check("R6 wake drops", {31'd0, wake}, 0);
    wt = 1'b0;

    // internal select
    ss_n = 1'b1;
    write_ctrl(8'h0B);
    idle(4);
    send_byte(8'h77, 1);
    drain();
    write_ctrl(8'h1B);
    ss_n = 1'b0; idle(4);
    send_byte(8'h66, 0);
    read_reg(1'b0, s);
    check("R2 soft deselect", {24'd0, s}, 32'h1B);

    // deselect discards partial byte
    write_ctrl(8'h03);
    idle(4);
    send_bits(8'hF0, 4);
    ss_n = 1'b1; idle(4);
    ss_n = 1'b0; idle(4);
    send_byte(8'hC3, 1);
    drain();

    // armed halt
    halt = 1'b1; idle(3);
    check("R7 no wake yet", {31'd0, wake}, 0);
    write_ctrl(8'h00);
    send_byte(8'h3E, 1);
    check("R7 wake in halt", {31'd0, wake}, 1);
    halt = 1'b0; idle(2);
    check("R9 wake ends with halt", {31'd0, wake}, 0);
    read_reg(1'b0, s);
    check("R8 write ignored in halt", {24'd0, s}, 32'h83);
    drain();
    send_byte(8'h44, 0);
    read_reg(1'b0, s);
    check("R10 recovery byte dropped", {24'd0, s}, 32'h03);
    send_byte(8'h45, 1);
    drain();

    // unarmed halt
    ss_n = 1'b1; idle(4);
    halt = 1'b1; idle(2);
    ss_n = 1'b0; idle(4);
    send_byte(8'h12, 0);
    check("R7 unarmed no wake", {31'd0, wake}, 0);
    halt = 1'b0; idle(2);
    read_reg(1'b0, s);
    check("R7 unarmed nothing stored", {24'd0, s}, 32'h03);
    write_ctrl(8'h00);
    write_ctrl(8'h03);
    idle(2);
    send_byte(8'h46, 1);
    drain();

    // mode fault
    ss_n = 1'b1; idle(4);
    write_ctrl(8'h07);
    idle(2);
    check("R11 master outputs on", {31'd0, outs_en}, 1);
    halt = 1'b1; idle(1);
    ss_n = 1'b0; idle(6);
    check("R8 no fault in halt", {31'd0, outs_en}, 1);
    check("R8 no irq in halt", {31'd0, irq}, 0);
    halt = 1'b0; idle(3);
    check("R11 outputs off", {31'd0, outs_en}, 0);
    check("R5 irq on fault", {31'd0, irq}, 1);
    read_reg(1'b0, s);
    check("R11 modf, master cleared", {24'd0, s}, 32'h23);
    read_reg(1'b1, d);
    read_reg(1'b0, s);
    check("R4 modf cleared", {24'd0, s}, 32'h03);

    check("R1 scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule